// File: doc/BRIEF.md
# Hall Commutation and Brake Logic

This block turns three Hall sensor bits and a direction bit into six gate enables for a three-phase bridge: one high-side and one low-side enable per phase. During the on-time of the chop command it drives one phase high and another low. During the off-time it applies slow-decay synchronous rectification. The load current then recirculates through both high-side switches or both low-side switches of the active pair, and the side alternates from one off-time to the next.

An active-low brake turns every low-side switch on. Sleep forces coast and outranks the brake. A disable flag and the two invalid Hall codes blank all gates. A dead time of programmable length separates the turn-off of one switch from the turn-on of its partner in the same phase. The Hall, direction, brake and chop inputs are synchronised, and the direction, brake and chop inputs are glitch filtered before use.

The sleep and disable flags come from logic in the same clock domain and act without synchronisation. All widths are in clock cycles and are set by parameters.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted all six gate enables are low.
- R2: With the direction bit at 1 and the chop command on, the Hall code written A,B,C (hallIn[2]=A, hallIn[1]=B, hallIn[0]=C) selects the driven pair as follows: 101 gives A high and C low, 100 gives B high and C low, 110 gives B high and A low, 010 gives C high and A low, 011 gives C high and B low, 001 gives A high and B low. In the gate vectors, bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. The third phase stays off.
- R3: With the direction bit at 0, every valid code uses the same two phases as in R2, with the high and low roles swapped.
- R4: Hall codes 000 and 111 turn all six gates off, for either direction.
- R5: With the brake input low and sleep inactive, all three low-side gates are on and all high-side gates are off. This holds whatever the chop, disable and Hall inputs are.
- R6: With sleep active, all gates are off, even while the brake is requested.
- R7: With disable active, brake released and sleep inactive, all gates are off.
- R8: While the chop command is off, both phases of the active pair are driven on the same side. The first off-time after reset uses the low side. Every new on command flips the side used by the following off-time.
- R9: When one gate of a phase turns off and its partner is requested, both gates stay low for exactly DEAD_CYC+1 clock cycles before the partner turns on.
- R10: A chop pulse shorter than CHOP_FILT clock cycles at the port is ignored. A pulse of CHOP_FILT cycles or longer is acted upon.
- R11: Direction or brake pulses shorter than DIRBRK_FILT cycles are ignored. A brake pulse of exactly DIRBRK_FILT cycles is acted upon.
- R12: The high-side and low-side enables of one phase are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallIn | input | 3 | Hall bits, [2]=A, [1]=B, [0]=C |
| dirIn | input | 1 | Commutation direction |
| brakeN | input | 1 | Active-low brake request |
| chopIn | input | 1 | Chop command, 1 = on-time |
| sleepIn | input | 1 | Sleep flag, forces coast |
| disableIn | input | 1 | Output disable flag |
| gateHi | output | 3 | High-side enables, bit 0 = phase A |
| gateLo | output | 3 | Low-side enables, bit 0 = phase A |

## Verification
The assertions treat the sleep and disable flags as synchronous to clk and state the brake, blanking and sleep rules against the filtered brake and the registered Hall code, not the raw pins. The dead-time and no-overlap checks assume only that requests reach the datapath as the control module forms them, never as a high and low request for one phase together. The bench changes every input just after the falling clock edge. It holds each level longer than the filter windows, except for the deliberate short pulses, and changes a Hall code or the direction only after the gates have settled.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int NUM_PH = 3;

  // strobes from control to the gate datapath
  typedef struct packed {
    logic [NUM_PH-1:0] hiReq;
    logic [NUM_PH-1:0] loReq;
  } gate_req_t;

  // driven pair for direction 1; phase index 0=A,1=B,2=C
  typedef struct packed {
    logic       valid;
    logic [1:0] srcPh;
    logic [1:0] snkPh;
  } hall_pair_t;

  function automatic hall_pair_t hall_pair(input logic [2:0] code);
    hall_pair_t p;
    p = '{valid: 1'b1, srcPh: 2'd0, snkPh: 2'd0};
    case (code)
      3'b101: begin p.srcPh = 2'd0; p.snkPh = 2'd2; end
      3'b100: begin p.srcPh = 2'd1; p.snkPh = 2'd2; end
      3'b110: begin p.srcPh = 2'd1; p.snkPh = 2'd0; end
      3'b010: begin p.srcPh = 2'd2; p.snkPh = 2'd0; end
      3'b011: begin p.srcPh = 2'd2; p.snkPh = 2'd1; end
      3'b001: begin p.srcPh = 2'd0; p.snkPh = 2'd1; end
      default: p.valid = 1'b0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cmt_input_filter.sv
module cmt_input_filter #(
  parameter int                WIDTH   = 1,
  parameter int                FILT    = 4,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [WIDTH-1:0] syncA, syncB;
  logic [CW-1:0]    holdCnt;

  // two-stage synchroniser, then accept a new level held for FILT cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= RST_VAL;
      syncB   <= RST_VAL;
      dout    <= RST_VAL;
      holdCnt <= '0;
    end else begin
      syncA <= din;
      syncB <= syncA;
      if (syncB == dout) begin
        holdCnt <= '0;
      end else if (holdCnt == LAST) begin
        dout    <= syncB;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl import cmt_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallF,
  input  logic       dirF,
  input  logic       brkNF,
  input  logic       chopF,
  input  logic       sleepIn,
  input  logic       disableIn,
  output gate_req_t  req
);
  logic       chopPrev;
  logic       recircHigh;
  hall_pair_t pair;
  logic [1:0] srcPh, snkPh;

  // recirculation side flips on every new on command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chopPrev   <= 1'b0;
      recircHigh <= 1'b0;
    end else begin
      chopPrev <= chopF;
      if (chopF && !chopPrev) recircHigh <= !recircHigh;
    end
  end

  always_comb begin
    pair  = hall_pair(hallF);
    srcPh = dirF ? pair.srcPh : pair.snkPh;
    snkPh = dirF ? pair.snkPh : pair.srcPh;
    req   = '0;
    if (sleepIn) begin
      req = '0;
    end else if (!brkNF) begin
      req.loReq = '1;
    end else if (disableIn || !pair.valid) begin
      req = '0;
    end else if (chopF) begin
      req.hiReq[srcPh] = 1'b1;
      req.loReq[snkPh] = 1'b1;
    end else if (recircHigh) begin
      req.hiReq[srcPh] = 1'b1;
      req.hiReq[snkPh] = 1'b1;
    end else begin
      req.loReq[srcPh] = 1'b1;
      req.loReq[snkPh] = 1'b1;
    end
  end

  // R12 precondition: never both requests for one phase
  p_req_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    (req.hiReq & req.loReq) == '0);
endmodule

// File: rtl/cmt_gate_dp.sv
module cmt_gate_dp import cmt_pkg::*; #(
  parameter int DEAD_CYC = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_req_t         req,
  output logic [NUM_PH-1:0] gateHi,
  output logic [NUM_PH-1:0] gateLo
);
  localparam int CW = $clog2(DEAD_CYC + 2);
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);
  localparam logic [CW-1:0] GAP_V  = CW'(DEAD_CYC + 1);

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_ph
    logic          hiQ, loQ;
    logic [CW-1:0] hiOff, loOff;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ   <= 1'b0;
        loQ   <= 1'b0;
        hiOff <= DEAD_V;
        loOff <= DEAD_V;
      end else begin
        hiQ   <= req.hiReq[ph] && !loQ && (loOff == DEAD_V);
        loQ   <= req.loReq[ph] && !hiQ && (hiOff == DEAD_V);
        hiOff <= hiQ ? '0 : ((hiOff == DEAD_V) ? hiOff : hiOff + CW'(1));
        loOff <= loQ ? '0 : ((loOff == DEAD_V) ? loOff : loOff + CW'(1));
      end
    end

    assign gateHi[ph] = hiQ;
    assign gateLo[ph] = loQ;

    // independent idle counters for the dead-time check
    logic [CW-1:0] hiIdle, loIdle;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiIdle <= GAP_V;
        loIdle <= GAP_V;
      end else begin
        hiIdle <= gateHi[ph] ? '0 : ((hiIdle == GAP_V) ? hiIdle : hiIdle + CW'(1));
        loIdle <= gateLo[ph] ? '0 : ((loIdle == GAP_V) ? loIdle : loIdle + CW'(1));
      end
    end

    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rstN)
      !(gateHi[ph] && gateLo[ph]));
    p_dead_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateHi[ph]) |-> (loIdle == GAP_V));
    p_dead_lo_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gateLo[ph]) |-> (hiIdle == GAP_V));
  end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator import cmt_pkg::*; #(
  parameter int DEAD_CYC    = 15,
  parameter int CHOP_FILT   = 90,
  parameter int DIRBRK_FILT = 100,
  parameter int HALL_FILT   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hallIn,
  input  logic       dirIn,
  input  logic       brakeN,
  input  logic       chopIn,
  input  logic       sleepIn,
  input  logic       disableIn,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo
);
  logic [2:0] hallF;
  logic       dirF, brkNF, chopF;
  gate_req_t  req;

  cmt_input_filter #(.WIDTH(3), .FILT(HALL_FILT), .RST_VAL(3'b000)) u_hall (
    .clk(clk), .rstN(rstN), .din(hallIn), .dout(hallF));
  cmt_input_filter #(.WIDTH(1), .FILT(DIRBRK_FILT), .RST_VAL(1'b1)) u_dir (
    .clk(clk), .rstN(rstN), .din(dirIn), .dout(dirF));
  cmt_input_filter #(.WIDTH(1), .FILT(DIRBRK_FILT), .RST_VAL(1'b0)) u_brk (
    .clk(clk), .rstN(rstN), .din(brakeN), .dout(brkNF));
  cmt_input_filter #(.WIDTH(1), .FILT(CHOP_FILT), .RST_VAL(1'b0)) u_chop (
    .clk(clk), .rstN(rstN), .din(chopIn), .dout(chopF));

  cmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hallF(hallF), .dirF(dirF), .brkNF(brkNF),
    .chopF(chopF), .sleepIn(sleepIn), .disableIn(disableIn), .req(req));

  cmt_gate_dp #(.DEAD_CYC(DEAD_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .req(req), .gateHi(gateHi), .gateLo(gateLo));

  p_brake_no_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!brkNF && !sleepIn) |=> (gateHi == 3'b000));
  p_sleep_coast_r6: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> ((gateHi | gateLo) == 3'b000));
  p_disable_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (disableIn && brkNF && !sleepIn) |=> ((gateHi | gateLo) == 3'b000));
  p_bad_hall_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((hallF == 3'b000 || hallF == 3'b111) && brkNF && !sleepIn)
      |=> ((gateHi | gateLo) == 3'b000));
endmodule

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;
  localparam int DEAD = 15;
  localparam int CF   = 90;
  localparam int DF   = 100;
  localparam int SETTLE = DF + DEAD + 20;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] hallIn;
  logic       dirIn, brakeN, chopIn, sleepIn, disableIn;
  logic [2:0] gateHi, gateLo;

  int checks = 0;
  int failed = 0;
  bit overlapSeen = 1'b0;

  always #5 clk = ~clk;

  bldc_commutator #(.DEAD_CYC(DEAD), .CHOP_FILT(CF), .DIRBRK_FILT(DF)) dut_i (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .dirIn(dirIn), .brakeN(brakeN),
    .chopIn(chopIn), .sleepIn(sleepIn), .disableIn(disableIn),
    .gateHi(gateHi), .gateLo(gateLo));

  always @(negedge clk)
    if (rstN && ((gateHi & gateLo) != 3'b000)) overlapSeen = 1'b1;

  task automatic chk(input string rq, input logic [2:0] eHi, input logic [2:0] eLo);
    checks++;
    if (gateHi !== eHi || gateLo !== eLo) begin
      failed++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", rq, gateHi, gateLo, eHi, eLo);
    end
  endtask

  task automatic chk_bit(input string rq, input bit ok, input string what);
    checks++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: %s (actual false, expected true)", rq, what);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  // drive pair per the requirement table; masks use bit0=A
  task automatic exp_pair(input logic [2:0] code, input logic dir,
                          output logic [2:0] eHi, output logic [2:0] eLo);
    logic [2:0] s, k;
    case (code)
      3'b101: begin s = 3'b001; k = 3'b100; end
      3'b100: begin s = 3'b010; k = 3'b100; end
      3'b110: begin s = 3'b010; k = 3'b001; end
      3'b010: begin s = 3'b100; k = 3'b001; end
      3'b011: begin s = 3'b100; k = 3'b010; end
      3'b001: begin s = 3'b001; k = 3'b010; end
      default: begin s = 3'b000; k = 3'b000; end
    endcase
    eHi = dir ? s : k;
    eLo = dir ? k : s;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset", 3'b000, 3'b000);
    rstN = 1'b1;
  endtask

  task automatic t_recirc();
    settle();
    chk("R8 first off-time low side", 3'b000, 3'b101);
    chopIn = 1'b1; settle();
    chk("R8 on-time", 3'b001, 3'b100);
    chopIn = 1'b0; settle();
    chk("R8 second off-time high side", 3'b101, 3'b000);
    chopIn = 1'b1; settle();
    chopIn = 1'b0; settle();
    chk("R8 third off-time low side", 3'b000, 3'b101);
    chopIn = 1'b1; settle();
  endtask

  task automatic t_decode(input logic dir, input string rq);
    logic [2:0] eHi, eLo;
    dirIn = dir;
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i == 7) continue;
      hallIn = 3'(i);
      settle();
      exp_pair(3'(i), dir, eHi, eLo);
      chk(rq, eHi, eLo);
    end
  endtask

  task automatic t_invalid();
    for (int d = 0; d < 2; d++) begin
      dirIn = d[0];
      hallIn = 3'b000; settle(); chk("R4 code 000", 3'b000, 3'b000);
      hallIn = 3'b111; settle(); chk("R4 code 111", 3'b000, 3'b000);
    end
    dirIn = 1'b1; hallIn = 3'b101; settle();
  endtask

  task automatic t_brake();
    brakeN = 1'b0; settle();
    chk("R5 brake", 3'b000, 3'b111);
    hallIn = 3'b111; chopIn = 1'b0; disableIn = 1'b1; settle();
    chk("R5 brake over bad hall, off-time and disable", 3'b000, 3'b111);
    disableIn = 1'b0; hallIn = 3'b101; chopIn = 1'b1; settle();
  endtask

  task automatic t_sleep();
    sleepIn = 1'b1; settle();
    chk("R6 sleep over brake", 3'b000, 3'b000);
    sleepIn = 1'b0; brakeN = 1'b1; settle();
    chk("R6 exit sleep", 3'b001, 3'b100);
  endtask

  task automatic t_disable();
    disableIn = 1'b1; settle();
    chk("R7 disable", 3'b000, 3'b000);
    disableIn = 1'b0; settle();
    chk("R7 re-enable", 3'b001, 3'b100);
  endtask

  task automatic t_dead();
    int gap = 0;
    int guard = 0;
    dirIn = 1'b0;
    while (gateHi[0] === 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
    while (gateLo[0] === 1'b0 && gap < 1000) begin gap++; @(negedge clk); end
    checks++;
    if (gap != DEAD + 1) begin
      failed++;
      $display("FAIL R9 dead gap: actual %0d expected %0d", gap, DEAD + 1);
    end
    settle();
    chk("R9 reversed pair after dead time", 3'b100, 3'b001);
    dirIn = 1'b1; settle();
  endtask

  task automatic t_chop_glitch();
    bit stable = 1'b1;
    bit moved  = 1'b0;
    chopIn = 1'b0;
    repeat (CF - 1) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b100) stable = 1'b0;
    end
    chopIn = 1'b1;
    repeat (2 * CF) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b100) stable = 1'b0;
    end
    chk_bit("R10 short chop pulse ignored", stable, "outputs unchanged");
    chopIn = 1'b0;
    repeat (CF) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b100) moved = 1'b1;
    end
    chopIn = 1'b1;
    repeat (CF + DEAD + 10) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b100) moved = 1'b1;
    end
    chk_bit("R10 full-width chop pulse acted on", moved, "outputs changed");
    settle();
    chk("R10 back to on-time", 3'b001, 3'b100);
  endtask

  task automatic t_dirbrk_glitch();
    bit stable = 1'b1;
    bit braked = 1'b0;
    brakeN = 1'b0;
    repeat (DF - 1) @(negedge clk);
    brakeN = 1'b1;
    dirIn = 1'b0;
    repeat (DF - 1) @(negedge clk);
    dirIn = 1'b1;
    repeat (2 * DF) begin
      @(negedge clk);
      if (gateHi !== 3'b001 || gateLo !== 3'b100) stable = 1'b0;
    end
    chk_bit("R11 short brake and direction pulses ignored", stable, "outputs unchanged");
    brakeN = 1'b0;
    repeat (DF) @(negedge clk);
    brakeN = 1'b1;
    repeat (DF + DEAD + 10) begin
      @(negedge clk);
      if (gateLo === 3'b111) braked = 1'b1;
    end
    chk_bit("R11 brake pulse of full width acted on", braked, "all lows seen");
    settle();
    chk("R11 recovered", 3'b001, 3'b100);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, failed);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    failed++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected completion)");
    report();
  end

  initial begin
    rstN = 1'b0; hallIn = 3'b101; dirIn = 1'b1; brakeN = 1'b1;
    chopIn = 1'b0; sleepIn = 1'b0; disableIn = 1'b0;
    t_reset();
    t_recirc();
    t_decode(1'b1, "R2 forward decode");
    t_decode(1'b0, "R3 reverse decode");
    dirIn = 1'b1; hallIn = 3'b101; settle();
    t_invalid();
    t_brake();
    t_sleep();
    t_disable();
    t_dead();
    t_chop_glitch();
    t_dirbrk_glitch();
    chk_bit("R12 no high/low overlap", !overlapSeen, "no overlap observed");
    report();
  end
endmodule